// File: doc/BRIEF.md
# Two-Path Gain-Ratio Background Calibrator

This block sits behind a converter whose gain stage alternates between two configurations on every other sample, so that the digital output acts like a two-way interleaved converter. Any gain mismatch between the two configurations puts an image tone at half the sample rate mirrored around the input. The block removes this image in the background. It multiplies each second-configuration sample by a running gain-ratio estimate. It chops the corrected stream with a sign that alternates every sample. It then scales the chopped error by a selectable power-of-two step and integrates it into the estimate. Together these form a loop that drives the image to zero.

Two independent ratio registers are kept, one for each configuration pair, selected by `pair_sel`. The calibration is run once per pair, and each pair's converged ratio stays available afterwards. A settle detector raises `converged` once the estimate has stopped moving for a long enough stretch. The estimate uses 20 fractional bits, so 2^20 represents a ratio of 1.0.

Top module: `gain_ratio_cal`

## Requirements
- R1: A sample with `in_path`=0 (first configuration) appears unchanged on `out_sample` one clock after it is accepted. `out_valid` is `in_valid` delayed by one clock.
- R2: A sample with `in_path`=1 (second configuration) is output as floor(x·r / 2^20), saturated to the signed `DW`-bit range. Here r is the selected pair's estimate as it stood before that clock.
- R3: When calibration is enabled, a first-path sample stores its corrected value c1. The following second-path sample with corrected value c2 forms the chopped pair error e = c1 − c2. The step floor(e·2^20 / 2^(12+`mu_sel`)) is then added to the selected pair's estimate, visible on `ratio_est` one clock later.
- R4: Each estimate saturates at 2^23−1 and −2^23 instead of wrapping.
- R5: After reset both estimates equal 2^20 (1.0), and `out_valid` and `converged` are 0.
- R6: While `cal_en` is 0, neither estimate nor the stored first-path value changes. Second-path samples are still corrected with the stored estimate.
- R7: An update changes only the estimate of the pair named by `pair_sel` (0 or 1). The other pair's register keeps its value.
- R8: A settle count increments on each enabled second-path update whose |step| is below `conv_thresh`, up to 1024. It clears on a larger step, and on an update for a pair other than the one last updated. `converged` is 1 exactly while the count is 1024.
- R9: With a constant input and a second-path gain g, the loop settles where the corrected second-path sample equals the first-path sample, so the estimate approaches 1/g and `converged` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Signed converter sample |
| in_path | input | 1 | 0 = first configuration, 1 = second configuration |
| pair_sel | input | 1 | Configuration pair whose ratio is used and trained |
| cal_en | input | 1 | Enables estimate updates |
| mu_sel | input | 3 | Step size exponent, step = 2^-(12+mu_sel) |
| conv_thresh | input | THR_W | Settle threshold on step magnitude, in 2^-20 units |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DW | Corrected signed sample |
| ratio_est | output | AW | Selected pair's ratio estimate, 20 fractional bits |
| converged | output | 1 | Estimate has settled |

## Verification
Correction and estimate update fall in the same cycle on every enabled second-path sample. The output must use the estimate from before that clock, while `ratio_est` must show the new value afterwards. The bench drives long alternating runs with enable high and compares both against an arithmetic model at every sample, so using the updated estimate one clock early would show at once. A second collision is a settle-count clear from a pair change, or from a large step, in the same update that would otherwise complete the count. It is provoked by switching pairs right after convergence and by a run with a wide threshold that must reach 1024 exactly.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
   localparam int MU_W = 3;
   typedef enum logic {PATH_FIRST = 1'b0, PATH_SECOND = 1'b1} path_e;
endpackage

// File: rtl/gcal_scaler.sv
module gcal_scaler #(
   parameter int DW            = 12,
   parameter int AW            = 24,
   parameter int FRAC          = 20,
   parameter bit ROUND_NEAREST = 1'b0
) (
   input  logic signed [DW-1:0] x,
   input  logic signed [AW-1:0] r,
   output logic signed [DW-1:0] y
);
   localparam int PW = DW + AW;
   localparam logic signed [PW-1:0] YMAX = PW'((64'sd1 <<< (DW-1)) - 64'sd1);
   localparam logic signed [PW-1:0] YMIN = -YMAX - PW'(64'sd1);

   if (FRAC < 1 || FRAC >= AW) begin : g_bad_frac
      $error("gcal_scaler: FRAC out of range");
   end

   logic signed [PW-1:0] prod, biased, shifted;
   assign prod = x * r;

   if (ROUND_NEAREST) begin : g_round
      localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (FRAC-1));
      assign biased = prod + HALF;
   end else begin : g_trunc
      assign biased = prod;
   end

   assign shifted = biased >>> FRAC;

   always_comb begin
      if (shifted > YMAX)      y = YMAX[DW-1:0];
      else if (shifted < YMIN) y = YMIN[DW-1:0];
      else                     y = shifted[DW-1:0];
   end
endmodule

// File: rtl/gcal_step.sv
module gcal_step #(
   parameter int DW        = 12,
   parameter int FRAC      = 20,
   parameter int STEP_BASE = 12,
   parameter int MU_W      = 3,
   parameter int DELTA_W   = 34
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic signed [DW-1:0]      y,
   input  logic                      second,
   input  logic                      load,
   input  logic [MU_W-1:0]           mu,
   output logic signed [DELTA_W-1:0] delta
);
   if (DELTA_W < DW + 2 + FRAC) begin : g_bad_dw
      $error("gcal_step: DELTA_W too narrow");
   end
   if (STEP_BASE + (1 << MU_W) > DELTA_W) begin : g_bad_shift
      $error("gcal_step: shift range exceeds DELTA_W");
   end

   logic signed [DW:0]        y_ext, chop, held;
   logic signed [DW+1:0]      pair_sum;
   logic signed [DELTA_W-1:0] wide;
   logic [7:0]                shamt;

   assign y_ext    = {y[DW-1], y};
   assign chop     = second ? -y_ext : y_ext;
   assign pair_sum = {held[DW], held} + {chop[DW], chop};
   assign wide     = DELTA_W'(pair_sum) <<< FRAC;
   assign shamt    = 8'(STEP_BASE) + 8'(mu);
   assign delta    = wide >>> shamt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held <= '0;
      else if (load) held <= chop;
   end
endmodule

// File: rtl/gcal_bank.sv
module gcal_bank #(
   parameter int NPAIR   = 2,
   parameter int AW      = 24,
   parameter int FRAC    = 20,
   parameter int DELTA_W = 34,
   localparam int SEL_W  = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         upd,
   input  logic [SEL_W-1:0]             sel,
   input  logic signed [DELTA_W-1:0]    delta,
   output logic [NPAIR-1:0][AW-1:0]     bank_q,
   output logic signed [AW-1:0]         ratio
);
   localparam int SUM_W = DELTA_W + 1;
   localparam logic signed [SUM_W-1:0] RMAX = SUM_W'((64'sd1 <<< (AW-1)) - 64'sd1);
   localparam logic signed [SUM_W-1:0] RMIN = -RMAX - SUM_W'(64'sd1);
   localparam logic [AW-1:0]           ONE  = AW'(64'd1 << FRAC);

   if (DELTA_W < AW) begin : g_bad_w
      $error("gcal_bank: DELTA_W must cover AW");
   end

   for (genvar g = 0; g < NPAIR; g++) begin : g_pair
      logic signed [SUM_W-1:0] sum;
      logic [AW-1:0]           next;
      assign sum = SUM_W'($signed(bank_q[g])) + SUM_W'(delta);
      always_comb begin
         if (sum > RMAX)      next = RMAX[AW-1:0];
         else if (sum < RMIN) next = RMIN[AW-1:0];
         else                 next = sum[AW-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           bank_q[g] <= ONE;
         else if (upd && sel == SEL_W'(g))     bank_q[g] <= next;
      end
   end

   assign ratio = $signed(bank_q[sel]);
endmodule

// File: rtl/gcal_settle.sv
module gcal_settle #(
   parameter int LEN     = 1024,
   parameter int DELTA_W = 34,
   parameter int THR_W   = 16,
   parameter int SEL_W   = 1,
   localparam int CW     = $clog2(LEN + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      upd,
   input  logic [SEL_W-1:0]          sel,
   input  logic signed [DELTA_W-1:0] delta,
   input  logic [THR_W-1:0]          thresh,
   output logic                      converged
);
   if (THR_W >= DELTA_W || LEN < 1) begin : g_bad_cfg
      $error("gcal_settle: bad threshold width or length");
   end

   logic [DELTA_W-1:0] mag;
   logic               quiet;
   logic [CW-1:0]      cnt;
   logic [SEL_W-1:0]   last_sel;

   assign mag       = delta[DELTA_W-1] ? DELTA_W'(-delta) : DELTA_W'(delta);
   assign quiet     = mag < {{(DELTA_W-THR_W){1'b0}}, thresh};
   assign converged = (cnt == CW'(LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         last_sel <= '0;
      end else if (upd) begin
         last_sel <= sel;
         if (sel != last_sel || !quiet) cnt <= '0;
         else if (cnt != CW'(LEN))      cnt <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/gain_ratio_cal.sv
module gain_ratio_cal
   import gcal_pkg::*;
#(
   parameter int DW            = 12,
   parameter int AW            = 24,
   parameter int FRAC          = 20,
   parameter int STEP_BASE     = 12,
   parameter int THR_W         = 16,
   parameter int SETTLE_LEN    = 1024,
   parameter bit ROUND_NEAREST = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_sample,
   input  logic                 in_path,
   input  logic                 pair_sel,
   input  logic                 cal_en,
   input  logic [MU_W-1:0]      mu_sel,
   input  logic [THR_W-1:0]     conv_thresh,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_sample,
   output logic signed [AW-1:0] ratio_est,
   output logic                 converged
);
   localparam int NPAIR   = 2;
   localparam int DELTA_W = DW + 2 + FRAC;

   if (DW < 2 || AW < FRAC + 2) begin : g_bad_top
      $error("gain_ratio_cal: width parameters inconsistent");
   end

   logic signed [DW-1:0]      scaled, corrected;
   logic signed [DELTA_W-1:0] step_delta;
   logic [NPAIR-1:0][AW-1:0]  bank_q;
   logic                      upd, load;
   path_e                     path;

   assign path      = path_e'(in_path);
   assign upd       = in_valid && cal_en && (path == PATH_SECOND);
   assign load      = in_valid && cal_en && (path == PATH_FIRST);
   assign corrected = (path == PATH_SECOND) ? scaled : in_sample;

   gcal_scaler #(.DW(DW), .AW(AW), .FRAC(FRAC), .ROUND_NEAREST(ROUND_NEAREST)) u_scaler (
      .x(in_sample), .r(ratio_est), .y(scaled));

   gcal_step #(.DW(DW), .FRAC(FRAC), .STEP_BASE(STEP_BASE), .MU_W(MU_W), .DELTA_W(DELTA_W)) u_step (
      .clk(clk), .rst_n(rst_n), .y(corrected), .second(in_path), .load(load),
      .mu(mu_sel), .delta(step_delta));

   gcal_bank #(.NPAIR(NPAIR), .AW(AW), .FRAC(FRAC), .DELTA_W(DELTA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .upd(upd), .sel(pair_sel), .delta(step_delta),
      .bank_q(bank_q), .ratio(ratio_est));

   gcal_settle #(.LEN(SETTLE_LEN), .DELTA_W(DELTA_W), .THR_W(THR_W), .SEL_W(1)) u_settle (
      .clk(clk), .rst_n(rst_n), .upd(upd), .sel(pair_sel), .delta(step_delta),
      .thresh(conv_thresh), .converged(converged));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sample <= corrected;
      end
   end
endmodule

// File: rtl/gcal_checker.sv
module gcal_checker #(
   parameter int DW      = 12,
   parameter int AW      = 24,
   parameter int DELTA_W = 34
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic                      in_path,
   input logic                      pair_sel,
   input logic                      cal_en,
   input logic signed [DW-1:0]      in_sample,
   input logic                      out_valid,
   input logic signed [DW-1:0]      out_sample,
   input logic                      converged,
   input logic [1:0][AW-1:0]        bank_q,
   input logic signed [DELTA_W-1:0] step_delta
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1
   AST_FIRST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_path) |=> (out_sample == $past(in_sample))); // R1
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_en) |=> $stable(bank_q)); // R6
   AST_PAIR0_KEEPS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (!pair_sel) |=> $stable(bank_q[1])); // R7
   AST_PAIR1_KEEPS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      pair_sel |=> $stable(bank_q[0])); // R7
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cal_en && in_path && !pair_sel && !step_delta[DELTA_W-1])
      |=> ($signed(bank_q[0]) >= $past($signed(bank_q[0])))); // R4
   AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (converged && !(in_valid && cal_en && in_path)) |=> converged); // R8
   AST_CONV_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(converged) |-> $past(in_valid && cal_en && in_path)); // R8
endmodule

bind gain_ratio_cal gcal_checker #(.DW(DW), .AW(AW), .DELTA_W(DELTA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_path(in_path),
   .pair_sel(pair_sel), .cal_en(cal_en), .in_sample(in_sample),
   .out_valid(out_valid), .out_sample(out_sample), .converged(converged),
   .bank_q(bank_q), .step_delta(step_delta));

// File: tb/tb_gain_ratio_cal.sv
module tb_gain_ratio_cal;
   localparam int  DW   = 12;
   localparam int  AW   = 24;
   localparam longint ONE  = 64'sd1 << 20;
   localparam longint RMAX = (64'sd1 <<< 23) - 1;
   localparam longint RMIN = -(64'sd1 <<< 23);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [DW-1:0] in_sample = '0;
   logic in_path = 1'b0;
   logic pair_sel = 1'b0;
   logic cal_en = 1'b0;
   logic [2:0] mu_sel = '0;
   logic [15:0] conv_thresh = 16'd1;
   logic out_valid;
   logic signed [DW-1:0] out_sample;
   logic signed [AW-1:0] ratio_est;
   logic converged;

   gain_ratio_cal dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .in_path(in_path), .pair_sel(pair_sel), .cal_en(cal_en), .mu_sel(mu_sel),
      .conv_thresh(conv_thresh), .out_valid(out_valid), .out_sample(out_sample),
      .ratio_est(ratio_est), .converged(converged));

   always #2.5 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   longint m_acc [2];
   longint m_held;
   int     m_cnt;
   int     m_last;

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint sat_dw(input longint v);
      if (v > 2047) return 2047;
      if (v < -2048) return -2048;
      return v;
   endfunction

   task automatic model_reset();
      m_acc[0] = ONE; m_acc[1] = ONE; m_held = 0; m_cnt = 0; m_last = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      in_valid = 1'b0; cal_en = 1'b0; pair_sel = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   // one accepted sample; checks outputs against the arithmetic model
   task automatic send(input int x, input bit p, input string req);
      longint y, c, s, d, mag;
      int pr;
      pr = int'(pair_sel);
      y = p ? sat_dw((longint'(x) * m_acc[pr]) >>> 20) : longint'(x);
      c = p ? -y : y;
      if (cal_en) begin
         if (!p) m_held = c;
         else begin
            s = m_held + c;
            d = (s <<< 20) >>> (12 + int'(mu_sel));
            m_acc[pr] = m_acc[pr] + d;
            if (m_acc[pr] > RMAX) m_acc[pr] = RMAX;
            if (m_acc[pr] < RMIN) m_acc[pr] = RMIN;
            mag = (d < 0) ? -d : d;
            if (pr != m_last || mag >= longint'(conv_thresh)) m_cnt = 0;
            else if (m_cnt < 1024) m_cnt++;
            m_last = pr;
         end
      end
      in_sample = DW'(x); in_path = p; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, "out_valid", longint'(out_valid), 1);
      check(req, "out_sample", longint'(out_sample), y);
      check(req, "ratio_est", longint'(ratio_est), m_acc[pr]);
      check("R8", "converged", longint'(converged), (m_cnt == 1024) ? 1 : 0);
   endtask

   task automatic peek_ratio(input bit pr, input longint exp, input string req);
      pair_sel = pr;
      #1;
      check(req, "stored ratio", longint'(ratio_est), exp);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 reset state
      check("R5", "out_valid after reset", longint'(out_valid), 0);
      check("R5", "converged after reset", longint'(converged), 0);
      peek_ratio(1'b0, ONE, "R5");
      peek_ratio(1'b1, ONE, "R5");
      pair_sel = 1'b0;

      // R1 exhaustive first-path sweep, calibration off
      for (int x = -2048; x < 2048; x++) send(x, 1'b0, "R1");
      @(negedge clk);
      check("R1", "out_valid drops", longint'(out_valid), 0);

      // R2 exhaustive second-path sweep at unity ratio
      for (int x = -2048; x < 2048; x++) send(x, 1'b1, "R2");

      // R3 single explicit step with mu=3
      do_reset();
      cal_en = 1'b1; mu_sel = 3'd3; conv_thresh = 16'd1;
      send(100, 1'b0, "R3");
      send(0, 1'b1, "R3");
      check("R3", "one step mu=3", longint'(ratio_est), ONE + 3200);

      // R9 convergence of pair 0, gain 0.8, mu=0
      do_reset();
      cal_en = 1'b1; mu_sel = 3'd0; conv_thresh = 16'd1;
      for (int k = 0; k < 5000 && !converged; k++) begin
         send(1000, 1'b0, "R3");
         send(800, 1'b1, "R3");
      end
      check("R9", "pair0 converged", longint'(converged), 1);
      check("R9", "pair0 ratio >= 1.25", (longint'(ratio_est) >= 1310720) ? 1 : 0, 1);
      check("R9", "pair0 ratio < 1.25+1/800", (longint'(ratio_est) < 1312031) ? 1 : 0, 1);
      send(800, 1'b1, "R9");
      check("R9", "image gone: corrected second path", longint'(out_sample), 1000);

      // R6 frozen estimate, sweep with stored ratio
      cal_en = 1'b0;
      for (int x = -2048; x < 2048; x += 3) begin
         send(x, 1'b0, "R6");
         send(x, 1'b1, "R2");
      end
      check("R6", "pair0 frozen", longint'(ratio_est), m_acc[0]);

      // R7/R8 second pair, gain 0.625, mu=2
      cal_en = 1'b1; mu_sel = 3'd2; pair_sel = 1'b1;
      send(1000, 1'b0, "R7");
      send(625, 1'b1, "R7");
      check("R8", "pair switch clears converged", longint'(converged), 0);
      for (int k = 0; k < 5000 && !converged; k++) begin
         send(1000, 1'b0, "R3");
         send(625, 1'b1, "R3");
      end
      check("R9", "pair1 converged", longint'(converged), 1);
      check("R9", "pair1 ratio >= 1.6", (longint'(ratio_est) >= 1677722) ? 1 : 0, 1);
      check("R9", "pair1 ratio < 1.6016", (longint'(ratio_est) < 1679399) ? 1 : 0, 1);
      peek_ratio(1'b0, m_acc[0], "R7");
      check("R7", "pair0 not at reset value", (m_acc[0] != ONE) ? 1 : 0, 1);

      // R8 exact count with a wide threshold
      do_reset();
      cal_en = 1'b1; mu_sel = 3'd0; conv_thresh = 16'hFFFF;
      for (int k = 0; k < 1023; k++) begin
         send(1000, 1'b0, "R8");
         send(800, 1'b1, "R8");
      end
      check("R8", "not yet at 1023 updates", longint'(converged), 0);
      send(1000, 1'b0, "R8");
      send(800, 1'b1, "R8");
      check("R8", "set at 1024 updates", longint'(converged), 1);
      conv_thresh = 16'd0;
      send(1000, 1'b0, "R8");
      send(800, 1'b1, "R8");
      check("R8", "cleared by large step", longint'(converged), 0);

      // R4 positive saturation
      do_reset();
      cal_en = 1'b1; mu_sel = 3'd0; conv_thresh = 16'd1;
      for (int k = 0; k < 12; k++) begin
         send(2047, 1'b0, "R4");
         send(-2048, 1'b1, "R4");
      end
      check("R4", "estimate clamps at max", longint'(ratio_est), RMAX);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule